// File: doc/BRIEF.md
# Host Mailbox Slave Port

This block sits between an external host bus and a small embedded controller core. The host sees a byte-wide slave port with an active-low select, active-low read and write strobes, and a one-bit register select (`hst_cd`). Through this port the host can leave a byte for the core, collect a byte that the core has left for it, and read a status byte. The status byte shows two buffer-full flags, a core-owned flag, a flag recording whether the host's last write was a command or data, and four bits whose meaning the core firmware defines.

The host strobes arrive without any relation to the core clock. Each qualified strobe passes through a synchroniser. Every effect of a host access is applied on the strobe's trailing edge, never on its leading edge. While the host holds a status read, the host-visible copy of the status byte is frozen, so the byte cannot change under the host during the read. Changes made inside the block in that time are collected, and the visible copy catches up once the read ends. The core side uses single-cycle command pulses to take the input byte, post an output byte, load the user status nibble and set the core-owned flag.

Top module: `mbx_host_port`

## Requirements
- R1: The status byte is laid out as follows. Bit 0 is output-full (OBF), bit 1 is input-full (IBF), bit 2 is the core flag F0, bit 3 is the command flag F1, and bits 7:4 are the user nibble.
- R2: A completed host write with `hst_sel_n` low loads `hst_wdata` into the input register and sets IBF. It also sets F1 to the `hst_cd` value of that access: 1 means command and 0 means data. These changes become visible on the third rising clock edge after the rising edge of `hst_wr_n`. The leading edge of the strobe changes nothing.
- R3: `hst_rdata` shows the host-visible status byte when `hst_cd` is 1 and the output register when `hst_cd` is 0.
- R4: A completed host read with `hst_cd` at 0 clears OBF on the third rising clock edge after the rising edge of `hst_rd_n`. A status read (`hst_cd` at 1) leaves OBF unchanged.
- R5: A read or write strobe has no effect while `hst_sel_n` is high.
- R6: A `loc_rd` pulse clears IBF on the next clock edge. If a host write completes on the same edge, IBF ends up set.
- R7: A `loc_wr` pulse loads `loc_wdata` into the output register and sets OBF on the next clock edge. If a host data read completes on the same edge, OBF ends up set.
- R8: A `loc_sts_ld` pulse copies `loc_wdata[7:4]` into status bits 7:4 on the next edge. Status bits 3:0 stay as they were.
- R9: The host-visible status byte follows the internal status with a lag of one clock. From the third clock edge after the leading edge of a status read until the third edge after that read's trailing edge, the visible byte holds its value. After that it takes on the current internal status.
- R10: Reset clears all four flags, the user nibble, both data registers and the visible status byte.
- R11: A `loc_f0_wr` pulse loads `loc_f0_val` into F0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_sel_n | input | 1 | Host select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_cd | input | 1 | Host register select: 1 for command/status, 0 for data |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data (status byte or output register) |
| loc_rd | input | 1 | Core pulse: take the input byte |
| loc_wr | input | 1 | Core pulse: post an output byte |
| loc_wdata | input | DW | Core operand for output byte and status load |
| loc_sts_ld | input | 1 | Core pulse: load the user status nibble |
| loc_f0_wr | input | 1 | Core pulse: load F0 |
| loc_f0_val | input | 1 | Value written to F0 |
| loc_rdata | output | DW | Input register contents |
| loc_ibf | output | 1 | Internal IBF flag |
| loc_obf | output | 1 | Internal OBF flag |
| loc_cmd | output | 1 | Internal F1 flag |

## Verification
A host strobe's effect on the flags and the input register is due on the third rising clock edge after the strobe rises. A core command takes effect on the first edge after the pulse. The host-visible status byte lags the internal flags by one more edge and stays frozen during the lock window set out in R9. The bench model records each stimulus as an event tagged with the edge on which it is due. It applies these events in the same clear-then-set order the design uses, and compares every output on each falling edge, so a result that arrives one edge early or late is reported. The directed checks in the bench read back values written as literals at known points, after each effect has had time to settle, to cover the layout, the collision priorities and the freeze.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // status byte bit positions (host software decodes these)
  localparam int STS_OBF     = 0;
  localparam int STS_IBF     = 1;
  localparam int STS_F0      = 2;
  localparam int STS_F1      = 3;
  localparam int STS_USR_LSB = 4;

  typedef struct packed {
    logic f1;
    logic f0;
    logic ibf;
    logic obf;
  } mbx_flags_t;

endpackage

// File: rtl/mbx_sync_bit.sv
module mbx_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_d = d;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/mbx_strobe_edge.sv
module mbx_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic active,
  output logic rise
);

  logic sync_n;
  logic last_q;
  logic last_d;

  mbx_sync_bit #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (strobe_n),
    .q     (sync_n)
  );

  assign last_d = sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_d;
  end

  assign active = ~sync_n;
  assign rise   = sync_n & ~last_q;

endmodule

// File: rtl/mbx_flag_core.sv
module mbx_flag_core
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_done,
  input  logic [DW-1:0] hw_data,
  input  logic          hw_cd,
  input  logic          hrd_data_done,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  input  logic          loc_sts_ld,
  input  logic          loc_f0_wr,
  input  logic          loc_f0_val,
  output logic [DW-1:0] din_q,
  output logic [DW-1:0] dout_q,
  output logic [DW-1:0] sts_live
);

  localparam int USR_W = DW - STS_USR_LSB;

  mbx_flags_t        flg_q, flg_d;
  logic [USR_W-1:0]  usr_q, usr_d;
  logic [DW-1:0]     din_d, dout_d;

  always_comb begin
    flg_d  = flg_q;
    usr_d  = usr_q;
    din_d  = din_q;
    dout_d = dout_q;
    // clears first, sets after: a set on the same edge wins
    if (loc_rd)        flg_d.ibf = 1'b0;
    if (hrd_data_done) flg_d.obf = 1'b0;
    if (hw_done) begin
      flg_d.ibf = 1'b1;
      flg_d.f1  = hw_cd;
      din_d     = hw_data;
    end
    if (loc_wr) begin
      flg_d.obf = 1'b1;
      dout_d    = loc_wdata;
    end
    if (loc_sts_ld) usr_d    = loc_wdata[DW-1:STS_USR_LSB];
    if (loc_f0_wr)  flg_d.f0 = loc_f0_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '0;
      usr_q  <= '0;
      din_q  <= '0;
      dout_q <= '0;
    end else begin
      flg_q  <= flg_d;
      usr_q  <= usr_d;
      din_q  <= din_d;
      dout_q <= dout_d;
    end
  end

  always_comb begin
    sts_live                          = '0;
    sts_live[STS_OBF]                 = flg_q.obf;
    sts_live[STS_IBF]                 = flg_q.ibf;
    sts_live[STS_F0]                  = flg_q.f0;
    sts_live[STS_F1]                  = flg_q.f1;
    sts_live[DW-1:STS_USR_LSB]        = usr_q;
  end

endmodule

// File: rtl/mbx_status_view.sv
module mbx_status_view #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic [DW-1:0] sts_live,
  output logic [DW-1:0] sts_vis
);

  logic [DW-1:0] vis_d;

  always_comb begin
    vis_d = sts_vis;
    if (!lock) vis_d = sts_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_vis <= '0;
    else        sts_vis <= vis_d;
  end

endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_sel_n,
  input  logic          hst_rd_n,
  input  logic          hst_wr_n,
  input  logic          hst_cd,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  input  logic          loc_sts_ld,
  input  logic          loc_f0_wr,
  input  logic          loc_f0_val,
  output logic [DW-1:0] loc_rdata,
  output logic          loc_ibf,
  output logic          loc_obf,
  output logic          loc_cmd
);

  logic          rst_n_s;
  logic          rd_qual_n, wr_qual_n;
  logic          rd_active, rd_rise;
  logic          wr_active, wr_rise;
  logic          cd_s;
  logic          sts_lock;
  logic          hrd_done;
  logic [DW-1:0] wr_data_hold_q, wr_data_hold_d;
  logic          wr_cd_hold_q, wr_cd_hold_d;
  logic          rd_cd_hold_q, rd_cd_hold_d;
  logic [DW-1:0] din_q, dout_q, sts_live, sts_vis;

  // reset: asserted at once, released through two flops
  mbx_sync_bit #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_s)
  );

  assign rd_qual_n = hst_rd_n | hst_sel_n;
  assign wr_qual_n = hst_wr_n | hst_sel_n;

  mbx_strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .strobe_n (rd_qual_n),
    .active   (rd_active),
    .rise     (rd_rise)
  );

  mbx_strobe_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .strobe_n (wr_qual_n),
    .active   (wr_active),
    .rise     (wr_rise)
  );

  mbx_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cd_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (hst_cd),
    .q     (cd_s)
  );

  // capture access attributes while a strobe is seen low
  always_comb begin
    wr_data_hold_d = wr_data_hold_q;
    wr_cd_hold_d   = wr_cd_hold_q;
    rd_cd_hold_d   = rd_cd_hold_q;
    if (wr_active) begin
      wr_data_hold_d = hst_wdata;
      wr_cd_hold_d   = cd_s;
    end
    if (rd_active) rd_cd_hold_d = cd_s;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_data_hold_q <= '0;
      wr_cd_hold_q   <= 1'b0;
      rd_cd_hold_q   <= 1'b0;
    end else begin
      wr_data_hold_q <= wr_data_hold_d;
      wr_cd_hold_q   <= wr_cd_hold_d;
      rd_cd_hold_q   <= rd_cd_hold_d;
    end
  end

  assign hrd_done = rd_rise & ~rd_cd_hold_q;
  assign sts_lock = rd_active & cd_s;

  mbx_flag_core #(.DW(DW)) u_core (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .hw_done       (wr_rise),
    .hw_data       (wr_data_hold_q),
    .hw_cd         (wr_cd_hold_q),
    .hrd_data_done (hrd_done),
    .loc_rd        (loc_rd),
    .loc_wr        (loc_wr),
    .loc_wdata     (loc_wdata),
    .loc_sts_ld    (loc_sts_ld),
    .loc_f0_wr     (loc_f0_wr),
    .loc_f0_val    (loc_f0_val),
    .din_q         (din_q),
    .dout_q        (dout_q),
    .sts_live      (sts_live)
  );

  mbx_status_view #(.DW(DW)) u_view (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lock     (sts_lock),
    .sts_live (sts_live),
    .sts_vis  (sts_vis)
  );

  assign hst_rdata = hst_cd ? sts_vis : dout_q;
  assign loc_rdata = din_q;
  assign loc_ibf   = sts_live[STS_IBF];
  assign loc_obf   = sts_live[STS_OBF];
  assign loc_cmd   = sts_live[STS_F1];

endmodule

// File: rtl/mbx_host_port_chk.sv
module mbx_host_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic          wr_rise,
  input logic          hrd_done,
  input logic          sts_lock,
  input logic          loc_rd,
  input logic          loc_wr,
  input logic          loc_sts_ld,
  input logic          loc_ibf,
  input logic          loc_obf,
  input logic [DW-1:0] loc_rdata,
  input logic [DW-1:0] sts_live,
  input logic [DW-1:0] sts_vis
);

  a_r2_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_rise |=> loc_ibf);

  a_r2_ibf_rises_only_on_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_rise |=> !$rose(loc_ibf));

  a_r2_din_held_between_writes: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_rise |=> $stable(loc_rdata));

  a_r4_data_read_clears_obf: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hrd_done && !loc_wr) |=> !loc_obf);

  a_r6_local_read_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n_s)
    (loc_rd && !wr_rise) |=> !loc_ibf);

  a_r7_local_write_sets_obf: assert property (@(posedge clk) disable iff (!rst_n_s)
    loc_wr |=> loc_obf);

  a_r7_obf_rises_only_on_local_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    !loc_wr |=> !$rose(loc_obf));

  a_r8_user_nibble_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    !loc_sts_ld |=> $stable(sts_live[DW-1:4]));

  a_r9_view_frozen_in_lock: assert property (@(posedge clk) disable iff (!rst_n_s)
    sts_lock |=> $stable(sts_vis));

endmodule

bind mbx_host_port mbx_host_port_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .wr_rise    (wr_rise),
  .hrd_done   (hrd_done),
  .sts_lock   (sts_lock),
  .loc_rd     (loc_rd),
  .loc_wr     (loc_wr),
  .loc_sts_ld (loc_sts_ld),
  .loc_ibf    (loc_ibf),
  .loc_obf    (loc_obf),
  .loc_rdata  (loc_rdata),
  .sts_live   (sts_live),
  .sts_vis    (sts_vis)
);

// File: tb/tb_mbx_host_port.sv
`timescale 1ns/100ps
module tb_mbx_host_port;

  localparam int HOLD  = 4;
  localparam int RHOLD = 8;
  localparam int K_LON = 0, K_LOFF = 1, K_LRD = 2, K_HRD = 3,
                 K_HWR = 4, K_LWR = 5, K_STS = 6, K_F0 = 7;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] d;
    logic       b;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hst_sel_n, hst_rd_n, hst_wr_n, hst_cd;
  logic [7:0] hst_wdata, hst_rdata;
  logic       loc_rd, loc_wr, loc_sts_ld, loc_f0_wr, loc_f0_val;
  logic [7:0] loc_wdata, loc_rdata;
  logic       loc_ibf, loc_obf, loc_cmd;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  ev_t        evq[$];
  ev_t        keep[$];
  logic       m_obf, m_ibf, m_f0, m_f1, m_lock;
  logic [3:0] m_usr;
  logic [7:0] m_din, m_dout, m_vis;

  always #2.5 clk = ~clk;

  mbx_host_port dut (
    .clk(clk), .rst_n(rst_n),
    .hst_sel_n(hst_sel_n), .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n),
    .hst_cd(hst_cd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
    .loc_sts_ld(loc_sts_ld), .loc_f0_wr(loc_f0_wr), .loc_f0_val(loc_f0_val),
    .loc_rdata(loc_rdata), .loc_ibf(loc_ibf), .loc_obf(loc_obf), .loc_cmd(loc_cmd)
  );

  function automatic logic [7:0] m_core();
    return {m_usr, m_f1, m_f0, m_ibf, m_obf};
  endfunction

  task automatic apply_kind(input int k);
    foreach (evq[i]) begin
      if (evq[i].due == cyc && evq[i].kind == k) begin
        case (k)
          K_LON:  m_lock = 1'b1;
          K_LOFF: m_lock = 1'b0;
          K_LRD:  m_ibf  = 1'b0;
          K_HRD:  m_obf  = 1'b0;
          K_HWR:  begin m_ibf = 1'b1; m_f1 = evq[i].b; m_din = evq[i].d; end
          K_LWR:  begin m_obf = 1'b1; m_dout = evq[i].d; end
          K_STS:  m_usr = evq[i].d[7:4];
          default: m_f0 = evq[i].b;
        endcase
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_obf = 0; m_ibf = 0; m_f0 = 0; m_f1 = 0; m_lock = 0;
      m_usr = '0; m_din = '0; m_dout = '0; m_vis = '0;
      evq.delete();
    end else begin
      cyc = cyc + 1;
      apply_kind(K_LON);
      apply_kind(K_LOFF);
      if (!m_lock) m_vis = m_core();
      apply_kind(K_LRD);
      apply_kind(K_HRD);
      apply_kind(K_HWR);
      apply_kind(K_LWR);
      apply_kind(K_STS);
      apply_kind(K_F0);
      keep.delete();
      foreach (evq[i]) if (evq[i].due > cyc) keep.push_back(evq[i]);
      evq = keep;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at cyc %0d", tag, act, exp, cyc);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R6 loc_ibf",   {7'd0, loc_ibf}, {7'd0, m_ibf});
      chk("R4 R7 loc_obf",   {7'd0, loc_obf}, {7'd0, m_obf});
      chk("R2 loc_cmd",      {7'd0, loc_cmd}, {7'd0, m_f1});
      chk("R2 loc_rdata",    loc_rdata, m_din);
      chk("R3 R9 hst_rdata", hst_rdata, hst_cd ? m_vis : m_dout);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int due, input int kind, input logic [7:0] d, input logic b);
    ev_t e;
    e.due = due; e.kind = kind; e.d = d; e.b = b;
    evq.push_back(e);
  endtask

  task automatic host_wr(input logic sel_n, input logic cd, input logic [7:0] d,
                         input int lrd_step);
    step();
    hst_sel_n = sel_n; hst_cd = cd; hst_wdata = d; hst_wr_n = 1'b0;
    for (int s = 1; s <= HOLD + 4; s++) begin
      step();
      loc_rd = 1'b0;
      if (s == lrd_step) begin loc_rd = 1'b1; push(cyc + 1, K_LRD, 8'h00, 1'b0); end
      if (s == HOLD) begin
        hst_wr_n = 1'b1;
        if (!sel_n) push(cyc + 3, K_HWR, d, cd);
      end
      if (s == HOLD + 3) begin hst_sel_n = 1'b1; hst_cd = 1'b0; hst_wdata = '0; end
    end
  endtask

  task automatic host_rd(input logic cd, input int lwr_step, input logic [7:0] lwd,
                         input string tag, input logic [7:0] exp);
    step();
    hst_sel_n = 1'b0; hst_cd = cd; hst_rd_n = 1'b0;
    if (cd) push(cyc + 3, K_LON, 8'h00, 1'b0);
    for (int s = 1; s <= RHOLD + 4; s++) begin
      step();
      loc_wr = 1'b0;
      if (s == lwr_step) begin
        loc_wr = 1'b1; loc_wdata = lwd; push(cyc + 1, K_LWR, lwd, 1'b0);
      end
      if (s == RHOLD - 1) chk(tag, hst_rdata, exp);
      if (s == RHOLD) begin
        hst_rd_n = 1'b1;
        if (cd) push(cyc + 3, K_LOFF, 8'h00, 1'b0);
        else    push(cyc + 3, K_HRD, 8'h00, 1'b0);
      end
      if (s == RHOLD + 3) begin hst_sel_n = 1'b1; hst_cd = 1'b0; end
    end
  endtask

  task automatic loc_cmd_pulse(input int kind, input logic [7:0] d, input logic b);
    step();
    case (kind)
      K_LRD:   loc_rd = 1'b1;
      K_LWR:   begin loc_wr = 1'b1; loc_wdata = d; end
      K_STS:   begin loc_sts_ld = 1'b1; loc_wdata = d; end
      default: begin loc_f0_wr = 1'b1; loc_f0_val = b; end
    endcase
    push(cyc + 1, kind, d, b);
    step();
    loc_rd = 0; loc_wr = 0; loc_sts_ld = 0; loc_f0_wr = 0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hst_sel_n = 1'b1; hst_rd_n = 1'b1; hst_wr_n = 1'b1; hst_cd = 1'b0; hst_wdata = '0;
    loc_rd = 0; loc_wr = 0; loc_wdata = '0; loc_sts_ld = 0; loc_f0_wr = 0; loc_f0_val = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();

    // R10 reset state
    chk("R10 ibf after reset", {7'd0, loc_ibf}, 8'h00);
    chk("R10 obf after reset", {7'd0, loc_obf}, 8'h00);
    chk("R10 din after reset", loc_rdata, 8'h00);
    chk("R10 dout after reset", hst_rdata, 8'h00);

    // R2 data write, then command write
    host_wr(1'b0, 1'b0, 8'hA5, -1);
    chk("R2 data write loads din", loc_rdata, 8'hA5);
    chk("R2 data write sets ibf", {7'd0, loc_ibf}, 8'h01);
    chk("R2 data write clears F1", {7'd0, loc_cmd}, 8'h00);
    host_wr(1'b0, 1'b1, 8'h3C, -1);
    chk("R2 command write sets F1", {7'd0, loc_cmd}, 8'h01);
    chk("R2 command write loads din", loc_rdata, 8'h3C);

    // R6 local read
    loc_cmd_pulse(K_LRD, 8'h00, 1'b0);
    chk("R6 local read clears ibf", {7'd0, loc_ibf}, 8'h00);

    // R5 deselected write ignored
    host_wr(1'b1, 1'b0, 8'h77, -1);
    chk("R5 deselected write keeps din", loc_rdata, 8'h3C);
    chk("R5 deselected write keeps ibf", {7'd0, loc_ibf}, 8'h00);
    chk("R5 deselected write keeps F1", {7'd0, loc_cmd}, 8'h01);

    // R7 local write; R1 status layout: obf|ibf|F1 = 0B
    loc_cmd_pulse(K_LWR, 8'h5A, 1'b0);
    chk("R7 local write sets obf", {7'd0, loc_obf}, 8'h01);
    host_wr(1'b0, 1'b1, 8'h11, -1);
    host_rd(1'b1, -1, 8'h00, "R1 R3 status byte layout", 8'h0B);
    chk("R4 status read keeps obf", {7'd0, loc_obf}, 8'h01);

    // R3 data read; R4 clears obf
    host_rd(1'b0, -1, 8'h00, "R3 data read returns dout", 8'h5A);
    chk("R4 data read clears obf", {7'd0, loc_obf}, 8'h00);

    // R9 freeze during status read while core posts a byte
    host_rd(1'b1, 4, 8'h66, "R9 status frozen during read", 8'h0A);
    chk("R7 obf set internally under lock", {7'd0, loc_obf}, 8'h01);
    host_rd(1'b1, -1, 8'h00, "R9 status catches up after read", 8'h0B);

    // R8 user nibble, R11 F0
    loc_cmd_pulse(K_STS, 8'hF3, 1'b0);
    host_rd(1'b1, -1, 8'h00, "R8 user nibble loaded low bits kept", 8'hFB);
    loc_cmd_pulse(K_F0, 8'h00, 1'b1);
    host_rd(1'b1, -1, 8'h00, "R11 F0 loaded", 8'hFF);

    // R6 collision: local read on the edge a host write completes
    host_wr(1'b0, 1'b0, 8'h42, HOLD + 2);
    chk("R6 write wins over local read", {7'd0, loc_ibf}, 8'h01);
    chk("R2 collision write loads din", loc_rdata, 8'h42);

    // R7 collision: local write on the edge a host data read completes
    host_rd(1'b0, RHOLD + 2, 8'h99, "R3 data read before collision", 8'h66);
    chk("R7 local write wins over data read", {7'd0, loc_obf}, 8'h01);
    host_rd(1'b0, -1, 8'h00, "R7 new byte after collision", 8'h99);
    chk("R4 second data read clears obf", {7'd0, loc_obf}, 8'h00);

    // R10 reset after activity
    rst_n = 1'b0;
    step();
    chk("R10 reset clears ibf", {7'd0, loc_ibf}, 8'h00);
    chk("R10 reset clears din", loc_rdata, 8'h00);
    hst_cd = 1'b1; #1;
    chk("R10 reset clears status", hst_rdata, 8'h00);
    hst_cd = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule